// File: doc/BRIEF.md
# Timer Output Compare Unit

This block pairs a 16-bit up-counter with a single output compare channel. On every enabled timer clock cycle the counter value is compared with a compare register. An equal value is a match. It raises a one-cycle match flag and drives a one-bit output-compare state through an action set by a 2-bit mode field: toggle, clear or set. A force strobe applies the same action without a real match, so software can preset the output state.

Any software write of the counter value blocks compare matches for the next enabled timer clock cycle. The block holds until that cycle comes, however long the timer clock is paused. This lets software load the counter with the compare value and not get a spurious match when counting resumes. In the variable-TOP counting mode, the same block also swallows the TOP detection. The mode field is applied without buffering. It also decides whether the output pin shows the compare state or the ordinary port data bit. The data-direction bit is the pin's output enable in every case.

Top module: `tmr_oc_unit`

## Requirements
- R1: A synchronous reset clears the counter to 0, the compare register to 0, the output-compare state to 0, the match flag to 0 and any pending match block.
- R2: In normal mode the counter advances by one on each cycle with `tick` high, wraps from 0xFFFF to 0x0000, and holds its value while `tick` is low.
- R3: With `var_top` high, a tick cycle in which the counter equals `top_val` (and is not blocked) loads 0 into the counter instead of incrementing.
- R4: A tick cycle in which the counter equals the compare register, with no block pending, raises `match_pulse` for exactly the following clock cycle.
- R5: A counter write loads `cnt_wdata` on the next edge and suppresses any match in the next tick cycle, even if `tick` stays low for many cycles in between; only that one tick cycle is suppressed.
- R6: With `var_top` high, writing a counter value equal to `top_val` makes the TOP detection miss, so the counter continues upward from the written value.
- R7: On a match or force, mode 01 toggles the output-compare state, 10 clears it, 11 sets it, and 00 leaves it unchanged.
- R8: `force_stb` applies the mode action to the output-compare state in the same way as a match but never raises `match_pulse`.
- R9: `pin_out` equals `port_data` when the mode field is 00 and the output-compare state otherwise, following a mode change immediately; `pin_oe` always equals `port_dir`.
- R10: The output-compare state holds its value across changes of the mode field and of `var_top` when no match or force occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable; the counter runs when high |
| var_top | input | 1 | 1 selects variable-TOP counting, 0 selects normal wrap |
| top_val | input | 16 | TOP value used in variable-TOP mode |
| cnt_wr | input | 1 | Software write strobe for the counter |
| cnt_wdata | input | 16 | Counter write value |
| cmp_wr | input | 1 | Software write strobe for the compare register |
| cmp_wdata | input | 16 | Compare register write value |
| com | input | 2 | Compare output mode: 00 off, 01 toggle, 10 clear, 11 set |
| force_stb | input | 1 | Force-compare strobe |
| port_dir | input | 1 | Port data-direction bit (output enable) |
| port_data | input | 1 | Port data bit used when the compare output is off |
| cnt_q | output | 16 | Current counter value |
| match_pulse | output | 1 | One-cycle compare match flag |
| pin_out | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable |

## Verification
A table of mode, direction, port data and force settings is walked with the timer paused. Each step tells the mode actions apart and shows that a force leaves the match flag low. It also shows whether the pin follows the compare state or the port bit. Directed counting runs then compare three cases: a match reached by counting, a write of the counter to the compare value followed by a long pause, and a write one below the compare value. Together they show that exactly one tick cycle is blocked. Wrap at 0xFFFF, TOP reset, a write of the counter to TOP, and a reset from a set output state cover the counter paths.

// File: rtl/tmr_oc_pkg.sv
package tmr_oc_pkg;

    localparam int unsigned CNT_W_DEF = 16;

    typedef enum logic [1:0] {
        OCM_OFF    = 2'b00,
        OCM_TOGGLE = 2'b01,
        OCM_CLEAR  = 2'b10,
        OCM_SET    = 2'b11
    } ocm_e;

    typedef struct packed {
        logic hit;     // real compare match this cycle
        logic forced;  // software force strobe this cycle
    } oc_event_t;

    typedef struct packed {
        logic dir;
        logic data;
    } port_bits_t;

    // Next output-compare state for an applied action.
    function automatic logic oc_next(input ocm_e mode, input logic cur);
        logic nxt;
        unique case (mode)
            OCM_TOGGLE: nxt = ~cur;
            OCM_CLEAR:  nxt = 1'b0;
            OCM_SET:    nxt = 1'b1;
            default:    nxt = cur;
        endcase
        return nxt;
    endfunction

    // The compare state owns the pin for every mode except off.
    function automatic logic ocm_owns_pin(input ocm_e mode);
        return mode != OCM_OFF;
    endfunction

endpackage

// File: rtl/tmr_oc_counter.sv
module tmr_oc_counter #(
    parameter int unsigned CNT_W       = tmr_oc_pkg::CNT_W_DEF,
    parameter bit          HAS_VAR_TOP = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             var_top,
    input  logic [CNT_W-1:0] top_val,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             blk,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic top_reset;

    generate
        if (HAS_VAR_TOP) begin : g_var_top
            assign top_reset = var_top && (cnt_q == top_val) && !blk;
        end else begin : g_fixed
            assign top_reset = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= ZERO;
        end else if (wr) begin
            cnt_q <= wdata;
        end else if (tick) begin
            cnt_q <= top_reset ? ZERO : cnt_q + ONE;
        end
    end

    // R2: normal mode increments by one per tick (wrap is modular)
    assert_count_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr && !var_top) |=> (cnt_q == $past(cnt_q) + ONE));

    // R2: counter holds while the timer clock is stopped
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr) |=> $stable(cnt_q));

    // R3: equal to TOP in variable-TOP mode restarts from zero
    assert_top_R3: assert property (@(posedge clk) disable iff (rst)
        (HAS_VAR_TOP && tick && !wr && var_top && !blk && cnt_q == top_val)
        |=> (cnt_q == ZERO));

    // R5: a software write loads the counter on the next edge
    assert_load_R5: assert property (@(posedge clk) disable iff (rst)
        wr |=> (cnt_q == $past(wdata)));

endmodule

// File: rtl/tmr_oc_compare.sv
module tmr_oc_compare #(
    parameter int unsigned CNT_W = tmr_oc_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic [CNT_W-1:0] cnt_q,
    output logic             blk_q,
    output logic             hit,
    output logic             match_q
);
    logic [CNT_W-1:0] cmp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
        end else if (cmp_wr) begin
            cmp_q <= cmp_wdata;
        end
    end

    // Block stays armed until the next enabled timer cycle consumes it.
    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q <= 1'b0;
        end else if (cnt_wr) begin
            blk_q <= 1'b1;
        end else if (tick) begin
            blk_q <= 1'b0;
        end
    end

    assign hit = tick && !cnt_wr && !blk_q && (cnt_q == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= 1'b0;
        end else begin
            match_q <= hit;
        end
    end

    // R4: a flag is only raised after a tick cycle with equal values
    assert_match_src_R4: assert property (@(posedge clk) disable iff (rst)
        match_q |-> $past(tick && cnt_q == cmp_q));

    // R4: the flag lasts one cycle while the timer runs past the value
    assert_match_once_R4: assert property (@(posedge clk) disable iff (rst)
        (match_q && !$past(cnt_wr) && tick && !cnt_wr && !cmp_wr)
        |=> !match_q || ($past(cnt_q) == cmp_q));

    // R5: the tick cycle following a counter write never matches
    assert_block_R5: assert property (@(posedge clk) disable iff (rst)
        (blk_q && tick) |=> !match_q);

endmodule

// File: rtl/tmr_oc_wave.sv
module tmr_oc_wave
    import tmr_oc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] com,
    input  oc_event_t  evt,
    input  port_bits_t port,
    output logic       pin_out,
    output logic       pin_oe
);
    ocm_e mode;
    logic act;
    logic oc_q;

    assign mode = ocm_e'(com);
    assign act  = evt.hit | evt.forced;

    always_ff @(posedge clk) begin
        if (rst) begin
            oc_q <= 1'b0;
        end else if (act) begin
            oc_q <= oc_next(mode, oc_q);
        end
    end

    // Mode field is used unbuffered: the pin source follows it at once.
    assign pin_out = ocm_owns_pin(mode) ? oc_q : port.data;
    assign pin_oe  = port.dir;

    // R7: clear action
    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (act && mode == OCM_CLEAR) |=> !oc_q);

    // R7: set action
    assert_set_R7: assert property (@(posedge clk) disable iff (rst)
        (act && mode == OCM_SET) |=> oc_q);

    // R7: toggle action
    assert_toggle_R7: assert property (@(posedge clk) disable iff (rst)
        (act && mode == OCM_TOGGLE) |=> (oc_q != $past(oc_q)));

    // R10: state held without an event, whatever the mode does
    assert_keep_R10: assert property (@(posedge clk) disable iff (rst)
        (!act || mode == OCM_OFF) |=> $stable(oc_q));

endmodule

// File: rtl/tmr_oc_unit.sv
module tmr_oc_unit
    import tmr_oc_pkg::*;
#(
    parameter int unsigned CNT_W       = CNT_W_DEF,
    parameter bit          HAS_VAR_TOP = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             var_top,
    input  logic [CNT_W-1:0] top_val,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic [1:0]       com,
    input  logic             force_stb,
    input  logic             port_dir,
    input  logic             port_data,
    output logic [CNT_W-1:0] cnt_q,
    output logic             match_pulse,
    output logic             pin_out,
    output logic             pin_oe
);
    logic       blk;
    logic       hit;
    oc_event_t  evt;
    port_bits_t port;

    assign evt.hit    = hit;
    assign evt.forced = force_stb;
    assign port.dir   = port_dir;
    assign port.data  = port_data;

    tmr_oc_counter #(
        .CNT_W       (CNT_W),
        .HAS_VAR_TOP (HAS_VAR_TOP)
    ) u_counter (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .var_top (var_top),
        .top_val (top_val),
        .wr      (cnt_wr),
        .wdata   (cnt_wdata),
        .blk     (blk),
        .cnt_q   (cnt_q)
    );

    tmr_oc_compare #(
        .CNT_W (CNT_W)
    ) u_compare (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cnt_wr    (cnt_wr),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (cmp_wdata),
        .cnt_q     (cnt_q),
        .blk_q     (blk),
        .hit       (hit),
        .match_q   (match_pulse)
    );

    tmr_oc_wave u_wave (
        .clk     (clk),
        .rst     (rst),
        .com     (com),
        .evt     (evt),
        .port    (port),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    // R8: a force alone, with no real match, leaves the flag low
    assert_force_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (force_stb && !hit) |=> !match_pulse);

endmodule

// File: tb/tmr_oc_unit_bench.sv
module tmr_oc_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        var_top = 1'b0;
    logic [15:0] top_val = 16'h0;
    logic        cnt_wr = 1'b0;
    logic [15:0] cnt_wdata = 16'h0;
    logic        cmp_wr = 1'b0;
    logic [15:0] cmp_wdata = 16'h0;
    logic [1:0]  com = 2'b00;
    logic        force_stb = 1'b0;
    logic        port_dir = 1'b0;
    logic        port_data = 1'b0;
    logic [15:0] cnt_q;
    logic        match_pulse;
    logic        pin_out;
    logic        pin_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tmr_oc_unit u_tmr_oc_unit (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .var_top     (var_top),
        .top_val     (top_val),
        .cnt_wr      (cnt_wr),
        .cnt_wdata   (cnt_wdata),
        .cmp_wr      (cmp_wr),
        .cmp_wdata   (cmp_wdata),
        .com         (com),
        .force_stb   (force_stb),
        .port_dir    (port_dir),
        .port_data   (port_data),
        .cnt_q       (cnt_q),
        .match_pulse (match_pulse),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe)
    );

    // Vector: {com[1:0], dir, data, force, exp_pin_out, exp_pin_oe}; timer paused.
    localparam int NV = 11;
    localparam logic [6:0] VEC [NV] = '{
        7'b11_1_0_1_1_1,  // set by force
        7'b01_1_0_1_0_1,  // toggle to 0
        7'b01_1_0_1_1_1,  // toggle to 1
        7'b10_0_0_0_1_0,  // clear mode, no force: held, oe off
        7'b10_1_0_1_0_1,  // clear by force
        7'b00_1_1_1_1_1,  // off: force ignored, pin shows port data
        7'b00_0_0_0_0_0,  // off: port data 0, oe off
        7'b11_1_1_0_0_1,  // set mode without force: pin shows held 0
        7'b11_1_0_1_1_1,  // set by force
        7'b00_1_0_1_0_1,  // off with force: state kept at 1
        7'b10_1_1_0_1_1   // clear mode, no event: still 1
    };

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cyc();
        rst = 1'b0;
        com = 2'b11;
        port_dir = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 cnt after reset", 32'(cnt_q), 32'h0);
        chk("R1 match after reset", 32'(match_pulse), 32'h0);
        chk("R1 oc state after reset", 32'(pin_out), 32'h0);

        // R7 R8 R9 R10: table walk with timer paused
        for (int i = 0; i < NV; i++) begin
            com       = VEC[i][6:5];
            port_dir  = VEC[i][4];
            port_data = VEC[i][3];
            force_stb = VEC[i][2];
            cyc();
            force_stb = 1'b0;
            chk($sformatf("R7/R9 pin_out vec %0d", i), 32'(pin_out), 32'(VEC[i][1]));
            chk($sformatf("R9 pin_oe vec %0d", i), 32'(pin_oe), 32'(VEC[i][0]));
            chk($sformatf("R8 no flag vec %0d", i), 32'(match_pulse), 32'h0);
        end
        // oc state is 1 here

        // R4: match reached by counting, toggle mode
        com = 2'b01; port_dir = 1'b1;
        cmp_wr = 1'b1; cmp_wdata = 16'h0010;
        cnt_wr = 1'b1; cnt_wdata = 16'h000E;
        cyc();
        cmp_wr = 1'b0; cnt_wr = 1'b0;
        chk("R5 cnt loaded", 32'(cnt_q), 32'h000E);
        tick = 1'b1;
        cyc(); cyc();
        chk("R4 cnt before match", 32'(cnt_q), 32'h0010);
        chk("R4 no early match", 32'(match_pulse), 32'h0);
        cyc();
        chk("R4 match flag", 32'(match_pulse), 32'h1);
        chk("R4 cnt after match", 32'(cnt_q), 32'h0011);
        chk("R7 toggle on match", 32'(pin_out), 32'h0);
        tick = 1'b0;
        cyc();
        chk("R4 flag one cycle", 32'(match_pulse), 32'h0);

        // R5: write counter equal to compare, pause, resume
        cnt_wr = 1'b1; cnt_wdata = 16'h0020;
        cmp_wr = 1'b1; cmp_wdata = 16'h0020;
        cyc();
        cnt_wr = 1'b0; cmp_wr = 1'b0;
        repeat (6) cyc();
        chk("R5 held while paused", 32'(cnt_q), 32'h0020);
        tick = 1'b1;
        cyc();
        tick = 1'b0;
        chk("R5 match blocked", 32'(match_pulse), 32'h0);
        chk("R5 pin unchanged", 32'(pin_out), 32'h0);
        chk("R5 cnt advanced", 32'(cnt_q), 32'h0021);

        // R5: only one tick cycle is blocked
        cnt_wr = 1'b1; cnt_wdata = 16'h001F;
        cyc();
        cnt_wr = 1'b0;
        tick = 1'b1;
        cyc();
        chk("R5 blocked cycle no flag", 32'(match_pulse), 32'h0);
        cyc();
        tick = 1'b0;
        chk("R5 later match allowed", 32'(match_pulse), 32'h1);
        chk("R5 toggle after block", 32'(pin_out), 32'h1);

        // R2: pause and wrap
        cnt_wr = 1'b1; cnt_wdata = 16'hFFFE;
        cyc();
        cnt_wr = 1'b0;
        repeat (3) cyc();
        chk("R2 stopped holds", 32'(cnt_q), 32'hFFFE);
        tick = 1'b1;
        cyc();
        chk("R2 count to FFFF", 32'(cnt_q), 32'hFFFF);
        cyc();
        chk("R2 wrap to 0", 32'(cnt_q), 32'h0000);
        tick = 1'b0;

        // R3: variable TOP
        var_top = 1'b1; top_val = 16'h0005;
        cnt_wr = 1'b1; cnt_wdata = 16'h0003;
        cyc();
        cnt_wr = 1'b0;
        chk("R10 oc kept on mode change", 32'(pin_out), 32'h1);
        tick = 1'b1;
        cyc();
        chk("R3 count 4", 32'(cnt_q), 32'h0004);
        cyc();
        chk("R3 reach TOP", 32'(cnt_q), 32'h0005);
        cyc();
        chk("R3 restart at 0", 32'(cnt_q), 32'h0000);
        tick = 1'b0;

        // R6: write equal to TOP misses the TOP reset
        cnt_wr = 1'b1; cnt_wdata = 16'h0005;
        cyc();
        cnt_wr = 1'b0;
        tick = 1'b1;
        cyc();
        chk("R6 passes TOP", 32'(cnt_q), 32'h0006);
        cyc();
        chk("R6 keeps counting", 32'(cnt_q), 32'h0007);
        tick = 1'b0;
        var_top = 1'b0;
        cyc();
        chk("R10 oc kept after var_top change", 32'(pin_out), 32'h1);

        // R1: reset from a set output state
        com = 2'b11;
        rst = 1'b1;
        cyc();
        rst = 1'b0;
        chk("R1 reset clears oc", 32'(pin_out), 32'h0);
        chk("R1 reset clears cnt", 32'(cnt_q), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule